// File: doc/BRIEF.md
# Phase-Compensation Clock-Crossing Buffer

This block carries a stream of words from a write clock domain into a read clock domain. The two clocks must run at exactly the same frequency, but the phase between them can be anything. Both clocks run without stopping. The buffer has no handshake and no full or empty flags. A source that registers samples on one clock phase can use it to hand its data to logic on another phase of the same clock.

After reset, the read side waits. It watches a two-stage synchronized copy of the Gray-coded write pointer. Reading starts only once that copy shows a set number of words stored, which is four by default. From then on, the read side takes one word on every read clock and flags every output word as valid. The upstream capture enable drives the write enable, and from the start of the stream it must write one word every write cycle. The number of cycles from input to output depends on which clock edge comes first, so it can change from one reset to the next.

Top module: `pcf_top`

## Requirements
- R1: While `rst_n` is low, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: `rd_valid` stays 0 while fewer than 4 words have been written since reset, including when `wr_en` is held low for a long time or exactly 3 words are written.
- R3: Once the 4th word is written, `rd_valid` rises within a bounded number of read cycles. With continuous writing that starts at a write-clock falling edge, `rd_valid` is first seen high between the 5th and 8th read-clock falling edge after that edge.
- R4: Once `rd_valid` is high, it stays high on every read cycle until reset.
- R5: The first valid `rd_data` is the first word written after reset. Each later valid word is the next word written, with no gap and no repeat.
- R6: R3 to R5 hold for any fixed phase offset between the two equal-frequency clocks.
- R7: Driving `rst_n` low clears `rd_valid` at once, without waiting for a clock edge. After release, the startup wait of R2 and R3 runs again.
- R8: The write pointer crosses domains in Gray code. Both the pointer and its synchronized copy change by at most one bit per clock.
- R9: The write pointer moves only on a write cycle with `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains, released synchronously in each |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Stores `wr_data` on this write cycle |
| wr_data | input | DW | Word to store |
| rd_clk | input | 1 | Read-side clock, same frequency as `wr_clk` |
| rd_data | output | DW | Word read out, registered |
| rd_valid | output | 1 | High when `rd_data` holds a stream word |

## Verification
The hardest situation to reach is the edge of the startup wait: the write count sits at exactly three, or the read edge falls just before or just after the write edge that stores the fourth word. The bench places the read clock at several sub-period delays from the write clock, including near-coincident edges and the inverted phase. It also writes exactly three words and then stalls, so it can watch whether reading starts one word too early. Each of these runs then streams consecutive words and compares every output against the word expected next.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  typedef enum logic {
    RD_FILL = 1'b0,
    RD_RUN  = 1'b1
  } rd_state_e;
endpackage

// File: rtl/pcf_rst_sync.sv
// Asynchronous assert, synchronous release reset for one clock domain.
module pcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pcf_bus_sync.sv
// Multi-stage synchronizer for a Gray-coded bus.
module pcf_bus_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic [W-1:0] stage_d;
      if (gi == 0) begin : g_first
        always_comb stage_d = d;
      end else begin : g_rest
        always_comb stage_d = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= '0;
        else        stage_q[gi] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pcf_wr_ctrl.sv
// Write-side pointer: binary address plus a registered Gray copy that crosses domains.
module pcf_wr_ctrl #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] wr_gray
);
  logic [AW-1:0] bin_q,  bin_d;
  logic [AW-1:0] gray_q, gray_d;
  logic          fire;

  always_comb begin
    fire   = wr_en;
    bin_d  = fire ? bin_q + 1'b1 : bin_q;
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (fire) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign wr_fire = fire & rst_n;
  assign wr_addr = bin_q;
  assign wr_gray = gray_q;

  assert_wr_gray_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);

  assert_wr_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(gray_q));
endmodule

// File: rtl/pcf_mem.sv
// Storage array: one synchronous write port, combinational read port.
module pcf_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/pcf_rd_ctrl.sv
// Read side: waits for the prefill level, then reads one word per cycle.
module pcf_rd_ctrl #(
  parameter int DW      = 16,
  parameter int AW      = 3,
  parameter int PREFILL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] wgray_sync,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  import pcf_pkg::*;

  localparam logic [AW-1:0] FILL_LEVEL = AW'(PREFILL);

  rd_state_e     state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] data_q, data_d;
  logic          vld_q, vld_d;
  logic [AW-1:0] wcount;
  logic          take;

  // Gray to binary. Before reading starts the read pointer is zero,
  // so this value is the number of words written.
  always_comb begin
    wcount[AW-1] = wgray_sync[AW-1];
    for (int i = AW - 2; i >= 0; i--) begin
      wcount[i] = wcount[i+1] ^ wgray_sync[i];
    end
  end

  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    case (state_q)
      RD_FILL: begin
        if (wcount >= FILL_LEVEL) begin
          state_d = RD_RUN;
          take    = 1'b1;
        end
      end
      RD_RUN:  take = 1'b1;
      default: state_d = RD_FILL;
    endcase
    ptr_d  = take ? ptr_q + 1'b1 : ptr_q;
    data_d = take ? mem_rdata : data_q;
    vld_d  = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_FILL;
      ptr_q   <= '0;
      data_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
      if (take) begin
        ptr_q  <= ptr_d;
        data_q <= data_d;
      end
    end
  end

  assign rd_addr  = ptr_q;
  assign rd_data  = data_q;
  assign rd_valid = vld_q;

  assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> vld_q);

  assert_no_early_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(wcount) >= FILL_LEVEL);

  assert_sync_gray_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray_sync ^ $past(wgray_sync)) <= 1);

  assert_ptr_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> ptr_q == '0);
endmodule

// File: rtl/pcf_top.sv
module pcf_top #(
  parameter int DW          = 16,
  parameter int DEPTH       = 8,
  parameter int PREFILL     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_rst_n, rd_rst_n;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [AW-1:0] wgray, wgray_sync;
  logic [DW-1:0] mem_rdata;

  pcf_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .arst_n(rst_n), .srst_n(wr_rst_n));

  pcf_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .arst_n(rst_n), .srst_n(rd_rst_n));

  pcf_wr_ctrl #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en),
    .wr_fire(we), .wr_addr(waddr), .wr_gray(wgray));

  pcf_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata));

  pcf_bus_sync #(.W(AW), .STAGES(SYNC_STAGES)) u_ptr_sync (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_sync));

  pcf_rd_ctrl #(.DW(DW), .AW(AW), .PREFILL(PREFILL)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .wgray_sync(wgray_sync),
    .mem_rdata(mem_rdata), .rd_addr(raddr), .rd_data(rd_data),
    .rd_valid(rd_valid));

  assert_reset_clears_R1: assert property (@(posedge rd_clk)
    !rst_n |-> (!rd_valid && rd_data == '0));
endmodule

// File: tb/tb_pcf_top.sv
`timescale 1ns/1ps
module tb_pcf_top;
  localparam int DW = 16;
  localparam int NV = 5;
  localparam int NWORDS = 40;
  localparam real PH [NV] = '{0.3, 1.25, 2.5, 3.7, 4.6};
  localparam int IDLE [NV] = '{4, 30, 7, 12, 5};
  localparam int BASE [NV] = '{16'h0100, 16'h7ffc, 16'hfff0, 16'h0a00, 16'h1234};

  logic rst_n, wr_clk, rd_clk, wr_en, rd_valid;
  logic [DW-1:0] wr_data, rd_data;
  real phase_ns;
  int n_chk, n_bad, wd;
  bit done;

  pcf_top #(.DW(DW)) dut (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_data(rd_data), .rd_valid(rd_valid));

  initial wr_clk = 1'b0;
  always #2.5 wr_clk = ~wr_clk;
  initial rd_clk = 1'b0;
  always @(wr_clk) rd_clk <= #(phase_ns) wr_clk;

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge wr_clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", wd);
      report();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    @(negedge wr_clk);
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (10) @(negedge wr_clk);
  endtask

  // Continuous stream starting at a write falling edge; checks R2..R6.
  task automatic stream(input int base, input int idle, input int nwords);
    int k;
    repeat (idle) @(negedge rd_clk);
    check(rd_valid == 1'b0, "R2 idle wr_en low", rd_valid, 0);
    @(negedge wr_clk);
    done = 1'b0;
    k = 0;
    fork
      begin
        while (!done) begin
          wr_en = 1'b1; wr_data = DW'(base + k); k++;
          @(negedge wr_clk);
        end
        wr_en = 1'b0;
      end
      begin
        int idx = 0, cnt = 0;
        while (idx < nwords) begin
          @(negedge rd_clk);
          cnt++;
          if (rd_valid) begin
            if (idx == 0) check(cnt >= 5 && cnt <= 8, "R3 start latency", cnt, 6);
            check(rd_data == DW'(base + idx), "R5 R6 sequence", rd_data, DW'(base + idx));
            idx++;
          end else if (idx > 0) begin
            check(1'b0, "R4 valid dropped", 0, 1);
            idx = nwords;
          end else if (cnt > 20) begin
            check(1'b0, "R3 never started", 0, 1);
            idx = nwords;
          end
        end
        done = 1'b1;
      end
    join
  endtask

  initial begin
    n_chk = 0; n_bad = 0; wd = 0; done = 1'b0;
    phase_ns = 1.0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (4) @(negedge wr_clk);
    // R1: reset state
    check(rd_valid == 1'b0, "R1 valid in reset", rd_valid, 0);
    check(rd_data == '0, "R1 data in reset", rd_data, 0);

    // Table walk: R6 phases, each a full R2..R5 stream
    for (int v = 0; v < NV; v++) begin
      phase_ns = PH[v];
      do_reset();
      stream(BASE[v], IDLE[v], NWORDS);
      check(rd_valid == 1'b1, "R4 still valid", rd_valid, 1);
    end

    // R2/R3 boundary: three words only, then the fourth
    phase_ns = 2.0;
    do_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge wr_clk); wr_en = 1'b1; wr_data = DW'(16'h5a00 + i);
    end
    @(negedge wr_clk); wr_en = 1'b0;
    repeat (12) begin
      @(negedge rd_clk);
      check(rd_valid == 1'b0, "R2 three words", rd_valid, 0);
    end
    @(negedge wr_clk); wr_en = 1'b1; wr_data = 16'h5a03;
    @(negedge wr_clk); wr_en = 1'b0;
    begin
      int c = 0;
      while (!rd_valid && c < 10) begin @(negedge rd_clk); c++; end
      check(rd_valid == 1'b1, "R3 fourth word starts read", rd_valid, 1);
      check(rd_data == 16'h5a00, "R5 first word", rd_data, 16'h5a00);
    end

    // R7: asynchronous clear during run, then restart
    phase_ns = 3.1;
    do_reset();
    stream(16'h3300, 4, 10);
    #1.3 rst_n = 1'b0;
    #0.4;
    check(rd_valid == 1'b0, "R7 async clear", rd_valid, 0);
    check(rd_data == '0, "R1 R7 data cleared", rd_data, 0);
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (10) @(negedge wr_clk);
    stream(16'h4400, 6, 20);

    report();
  end
endmodule